// File: doc/BRIEF.md
# Central Domain Stop Arbiter

This block is the point where fatal-error stop requests from the whole machine come together before any stop is declared. Up to `NE` expander concentrators and `NX` centerplane switch units raise requests. A twin arbiter on the other half of the centerplane reaches this one over a pair of notify links. The arbiter takes one event, records it, and sends a demand message to every switch unit and every expander concentrator. The message carries the stop kind, the expander in error and the slots involved.

Alongside the demand it drives a per-port stop mask for the crossbar. An errored port that is split stops only itself, and the expander finishes the job. An errored port that is not split also stops every other non-split port it can talk to. A static communication matrix says which ports can talk. The arbiter then waits until every resource has acknowledged the demand. Only then does it interrupt the system controller, and it stays in that state until software clears it.

The demand output is a valid/ready stream. Once `dem_valid` rises, the payload holds steady until the cycle in which `dem_ready` is also high. The transport may hold `dem_ready` low for as long as it needs. Stop requests, notify links, acknowledges, configuration and the interrupt are plain level or pulse signals and have no handshake.

Top module: `dstop_arbiter`

## Requirements
- R1: After reset the arbiter is idle. `dem_valid`, `peer_out_valid`, `sc_irq` and every bit of `port_stop` are 0.
- R2: When several requests arrive in the same cycle, the one naming the lowest port index wins. A request from expander `i` names port `i`. A switch-unit request names its `xu_port` field, and the peer notify names `peer_in_port`. If two sources name the same winning port, the expander beats the switch unit, which beats the peer.
- R3: `dem_valid` rises in the cycle after the winning request is sampled. It carries `dem_type` (0 = domain stop, 1 = reset stop), `dem_port` and `dem_slots` (one bit per slot, bit k = slot k). While `dem_ready` is low, the valid flag and the payload stay unchanged.
- R4: For a non-split errored port p, `port_stop` has bit p set. It also has bit q set for every non-split q whose bit `comm_cfg[p*NE+q]` is 1. All other bits are 0.
- R5: For a split errored port p (`split_cfg[p]` = 1), `port_stop` has only bit p set.
- R6: When the winner came from a local source (expander or switch unit), `peer_out_valid` pulses for exactly the first demand cycle and carries the same type, port and slots. When the winner came from the peer notify, no pulse is sent.
- R7: `sc_irq` rises only after the demand has been accepted and every bit of `ack` has been seen high at least once since then. The bits may arrive in any order and in any cycles. Acknowledges seen before the demand is accepted count for nothing.
- R8: Once an event is held, any further requests or notifies are ignored. A `sw_clear` pulse returns the block to the reset state in the next cycle, and no ignored request is left pending.
- R9: Once high, `sc_irq` stays high until `sw_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sw_clear | input | 1 | Software clear of the held event |
| exp_req | input | NE | Stop request per expander concentrator |
| exp_type | input | NE | Stop kind per expander (1 = reset stop) |
| exp_slots | input | NE*NS | Errored slot mask per expander |
| xu_req | input | NX | Stop request per switch unit |
| xu_type | input | NX | Stop kind per switch unit |
| xu_port | input | NX*PW | Errored port named by each switch unit |
| peer_in_valid | input | 1 | Notify from twin arbiter |
| peer_in_type | input | 1 | Stop kind on the notify |
| peer_in_port | input | PW | Errored port on the notify |
| peer_in_slots | input | NS | Errored slots on the notify |
| split_cfg | input | NE | Port is a split expander |
| comm_cfg | input | NE*NE | Bit p*NE+q: port p can talk to port q |
| peer_out_valid | output | 1 | Notify to twin arbiter |
| peer_out_type | output | 1 | Stop kind sent to twin |
| peer_out_port | output | PW | Errored port sent to twin |
| peer_out_slots | output | NS | Errored slots sent to twin |
| dem_valid | output | 1 | Demand broadcast valid |
| dem_ready | input | 1 | Demand transport ready |
| dem_type | output | 1 | Demand stop kind |
| dem_port | output | PW | Demand errored port |
| dem_slots | output | NS | Demand errored slots |
| port_stop | output | NE | Crossbar port stop mask |
| ack | input | NR | Per-resource acknowledge of the demand |
| sc_irq | output | 1 | Interrupt to system controller |

## Verification
If the winner register is wrong, it shows up in `dem_port` and `port_stop` one cycle after the request. A bad split or communication decode shows on `port_stop` in that same first cycle. If the acknowledge collector is wrong, `sc_irq` rises one cycle too early, right after a partial set of acknowledges, or never rises at all. The directed scenarios time each of these to the exact cycle. If the held-event state leaks, a later or ignored request shows up as a changed `dem_port` while the demand is still back-pressured, or as a fresh demand right after `sw_clear`.

// File: rtl/dstop_pkg.sv
`timescale 1ns/1ps
package dstop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } dstop_state_e;

  localparam logic KIND_DOMAIN = 1'b0;
  localparam logic KIND_RESET  = 1'b1;
endpackage

// File: rtl/dstop_pick.sv
`timescale 1ns/1ps
// Chooses one stop event among expander, switch-unit and peer sources.
module dstop_pick #(
  parameter int NE = 8,
  parameter int NX = 4,
  parameter int NS = 2,
  parameter int PW = 3
) (
  input  logic [NE-1:0]    exp_req,
  input  logic [NE-1:0]    exp_type,
  input  logic [NE*NS-1:0] exp_slots,
  input  logic [NX-1:0]    xu_req,
  input  logic [NX-1:0]    xu_type,
  input  logic [NX*PW-1:0] xu_port,
  input  logic             peer_valid,
  input  logic             peer_type,
  input  logic [PW-1:0]    peer_port,
  input  logic [NS-1:0]    peer_slots,
  output logic             win_valid,
  output logic             win_local,
  output logic             win_type,
  output logic [PW-1:0]    win_port,
  output logic [NS-1:0]    win_slots
);
  // Sources are scanned expanders, then switch units, then peer;
  // strict less-than keeps the earlier source on an equal port.
  always_comb begin
    win_valid = 1'b0;
    win_local = 1'b0;
    win_type  = 1'b0;
    win_port  = '0;
    win_slots = '0;
    for (int i = 0; i < NE; i++) begin
      if (exp_req[i] && (!win_valid || (PW'(i) < win_port))) begin
        win_valid = 1'b1;
        win_local = 1'b1;
        win_type  = exp_type[i];
        win_port  = PW'(i);
        win_slots = exp_slots[i*NS +: NS];
      end
    end
    for (int j = 0; j < NX; j++) begin
      if (xu_req[j] && (int'(xu_port[j*PW +: PW]) < NE) &&
          (!win_valid || (xu_port[j*PW +: PW] < win_port))) begin
        win_valid = 1'b1;
        win_local = 1'b1;
        win_type  = xu_type[j];
        win_port  = xu_port[j*PW +: PW];
        win_slots = '0;
      end
    end
    if (peer_valid && (int'(peer_port) < NE) &&
        (!win_valid || (peer_port < win_port))) begin
      win_valid = 1'b1;
      win_local = 1'b0;
      win_type  = peer_type;
      win_port  = peer_port;
      win_slots = peer_slots;
    end
  end
endmodule

// File: rtl/dstop_mask.sv
`timescale 1ns/1ps
// Crossbar stop mask for one errored port.
module dstop_mask #(
  parameter int NE = 8,
  parameter int PW = 3
) (
  input  logic [PW-1:0]    err_port,
  input  logic [NE-1:0]    split_cfg,
  input  logic [NE*NE-1:0] comm_cfg,
  output logic [NE-1:0]    stop_mask
);
  logic [NE-1:0] row;
  logic          err_split;

  always_comb begin
    row       = '0;
    err_split = 1'b0;
    for (int p = 0; p < NE; p++) begin
      if (err_port == PW'(p)) begin
        row       = comm_cfg[p*NE +: NE];
        err_split = split_cfg[p];
      end
    end
  end

  for (genvar q = 0; q < NE; q++) begin : g_bit
    assign stop_mask[q] = (err_port == PW'(q)) ||
                          (!err_split && !split_cfg[q] && row[q]);
  end
endmodule

// File: rtl/dstop_ackcol.sv
`timescale 1ns/1ps
// Collects acknowledges from every resource while enabled.
module dstop_ackcol #(
  parameter int NR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NR-1:0] ack,
  output logic          all_seen
);
  logic [NR-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) seen_q <= '0;
    else               seen_q <= seen_q | ack;
  end

  assign all_seen = en && (&(seen_q | ack));
endmodule

// File: rtl/dstop_arbiter.sv
`timescale 1ns/1ps
module dstop_arbiter #(
  parameter int NE = 8,
  parameter int NX = 4,
  parameter int NS = 2,
  parameter int NR = 4,
  localparam int PW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clear,
  input  logic [NE-1:0]    exp_req,
  input  logic [NE-1:0]    exp_type,
  input  logic [NE*NS-1:0] exp_slots,
  input  logic [NX-1:0]    xu_req,
  input  logic [NX-1:0]    xu_type,
  input  logic [NX*PW-1:0] xu_port,
  input  logic             peer_in_valid,
  input  logic             peer_in_type,
  input  logic [PW-1:0]    peer_in_port,
  input  logic [NS-1:0]    peer_in_slots,
  input  logic [NE-1:0]    split_cfg,
  input  logic [NE*NE-1:0] comm_cfg,
  output logic             peer_out_valid,
  output logic             peer_out_type,
  output logic [PW-1:0]    peer_out_port,
  output logic [NS-1:0]    peer_out_slots,
  output logic             dem_valid,
  input  logic             dem_ready,
  output logic             dem_type,
  output logic [PW-1:0]    dem_port,
  output logic [NS-1:0]    dem_slots,
  output logic [NE-1:0]    port_stop,
  input  logic [NR-1:0]    ack,
  output logic             sc_irq
);
  import dstop_pkg::*;

  dstop_state_e  state_q;
  logic          ev_type_q;
  logic [PW-1:0] ev_port_q;
  logic [NS-1:0] ev_slots_q;
  logic [NE-1:0] ev_mask_q;
  logic          notify_q;

  logic          win_valid, win_local, win_type;
  logic [PW-1:0] win_port;
  logic [NS-1:0] win_slots;
  logic [NE-1:0] win_mask;
  logic          acks_done;

  dstop_pick #(.NE(NE), .NX(NX), .NS(NS), .PW(PW)) u_pick (
    .exp_req    (exp_req),
    .exp_type   (exp_type),
    .exp_slots  (exp_slots),
    .xu_req     (xu_req),
    .xu_type    (xu_type),
    .xu_port    (xu_port),
    .peer_valid (peer_in_valid),
    .peer_type  (peer_in_type),
    .peer_port  (peer_in_port),
    .peer_slots (peer_in_slots),
    .win_valid  (win_valid),
    .win_local  (win_local),
    .win_type   (win_type),
    .win_port   (win_port),
    .win_slots  (win_slots)
  );

  dstop_mask #(.NE(NE), .PW(PW)) u_mask (
    .err_port  (win_port),
    .split_cfg (split_cfg),
    .comm_cfg  (comm_cfg),
    .stop_mask (win_mask)
  );

  dstop_ackcol #(.NR(NR)) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (state_q == ST_WAIT),
    .ack      (ack),
    .all_seen (acks_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || sw_clear) begin
      state_q    <= ST_IDLE;
      ev_type_q  <= KIND_DOMAIN;
      ev_port_q  <= '0;
      ev_slots_q <= '0;
      ev_mask_q  <= '0;
      notify_q   <= 1'b0;
    end else begin
      notify_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (win_valid) begin
          state_q    <= ST_SEND;
          ev_type_q  <= win_type;
          ev_port_q  <= win_port;
          ev_slots_q <= win_slots;
          ev_mask_q  <= win_mask;
          notify_q   <= win_local;
        end
        ST_SEND: if (dem_ready) state_q <= ST_WAIT;
        ST_WAIT: if (acks_done) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dem_valid      = (state_q == ST_SEND);
  assign dem_type       = ev_type_q;
  assign dem_port       = ev_port_q;
  assign dem_slots      = ev_slots_q;
  assign port_stop      = ev_mask_q;
  assign sc_irq         = (state_q == ST_DONE);
  assign peer_out_valid = notify_q;
  assign peer_out_type  = ev_type_q;
  assign peer_out_port  = ev_port_q;
  assign peer_out_slots = ev_slots_q;
endmodule

// File: rtl/dstop_arbiter_chk.sv
`timescale 1ns/1ps
module dstop_arbiter_chk #(
  parameter int NE = 8,
  parameter int NS = 2,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_clear,
  input logic          dem_valid,
  input logic          dem_ready,
  input logic          dem_type,
  input logic [PW-1:0] dem_port,
  input logic [NS-1:0] dem_slots,
  input logic [NE-1:0] port_stop,
  input logic          peer_out_valid,
  input logic          sc_irq
);
  a_r3_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    dem_valid && !dem_ready && !sw_clear |=>
      dem_valid && $stable(dem_port) && $stable(dem_type) && $stable(dem_slots));

  a_r4_err_port_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    dem_valid |-> port_stop[dem_port]);

  a_r6_notify_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    peer_out_valid |=> !peer_out_valid);

  a_r6_notify_with_demand: assert property (@(posedge clk) disable iff (!rst_n)
    peer_out_valid |-> dem_valid);

  a_r7_irq_after_demand: assert property (@(posedge clk) disable iff (!rst_n)
    sc_irq |-> !dem_valid && !peer_out_valid);

  a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> !dem_valid && !sc_irq && (port_stop == '0));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sc_irq && !sw_clear |=> sc_irq);
endmodule

bind dstop_arbiter dstop_arbiter_chk #(.NE(NE), .NS(NS), .PW(PW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_clear       (sw_clear),
  .dem_valid      (dem_valid),
  .dem_ready      (dem_ready),
  .dem_type       (dem_type),
  .dem_port       (dem_port),
  .dem_slots      (dem_slots),
  .port_stop      (port_stop),
  .peer_out_valid (peer_out_valid),
  .sc_irq         (sc_irq)
);

// File: tb/tb_dstop_arbiter.sv
`timescale 1ns/1ps
module tb_dstop_arbiter;
  localparam int NE = 8;
  localparam int NX = 4;
  localparam int NS = 2;
  localparam int NR = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_clear = 1'b0;
  logic [NE-1:0] exp_req = '0, exp_type = '0;
  logic [NE*NS-1:0] exp_slots = '0;
  logic [NX-1:0] xu_req = '0, xu_type = '0;
  logic [NX*PW-1:0] xu_port = '0;
  logic peer_in_valid = 1'b0, peer_in_type = 1'b0;
  logic [PW-1:0] peer_in_port = '0;
  logic [NS-1:0] peer_in_slots = '0;
  logic [NE-1:0] split_cfg = '0;
  logic [NE*NE-1:0] comm_cfg = '0;
  logic peer_out_valid, peer_out_type, dem_valid, dem_type, sc_irq;
  logic [PW-1:0] peer_out_port, dem_port;
  logic [NS-1:0] peer_out_slots, dem_slots;
  logic [NE-1:0] port_stop;
  logic dem_ready = 1'b1;
  logic [NR-1:0] ack = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dstop_arbiter #(.NE(NE), .NX(NX), .NS(NS), .NR(NR)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // Mask the requirements call for: errored port, plus non-split partners.
  function automatic logic [NE-1:0] want_mask(input int p);
    logic [NE-1:0] m = '0;
    m[p] = 1'b1;
    if (!split_cfg[p])
      for (int q = 0; q < NE; q++)
        if (!split_cfg[q] && comm_cfg[p*NE+q]) m[q] = 1'b1;
    return m;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic clear_all();
    sw_clear = 1'b1; step(); sw_clear = 1'b0;
  endtask

  task automatic finish_event();
    ack = '1; step(); ack = '0;
    eq("R7", "irq after full ack", sc_irq, 1);
    step();
    eq("R9", "irq sticky", sc_irq, 1);
    clear_all();
    eq("R8", "irq after clear", sc_irq, 0);
    eq("R8", "stop mask after clear", port_stop, 0);
  endtask

  task automatic t_reset();
    eq("R1", "dem_valid", dem_valid, 0);
    eq("R1", "port_stop", port_stop, 0);
    eq("R1", "sc_irq", sc_irq, 0);
    eq("R1", "peer_out_valid", peer_out_valid, 0);
  endtask

  task automatic t_nonsplit();
    exp_req[2] = 1; exp_type[2] = 0; exp_slots[2*NS +: NS] = 2'b10;
    step(); exp_req = '0;
    eq("R3", "dem_valid", dem_valid, 1);
    eq("R3", "dem_port", dem_port, 2);
    eq("R3", "dem_type domain", dem_type, 0);
    eq("R3", "dem_slots", dem_slots, 2'b10);
    eq("R4", "non-split mask", port_stop, want_mask(2));
    eq("R6", "notify pulse", peer_out_valid, 1);
    eq("R6", "notify port", peer_out_port, 2);
    eq("R6", "notify slots", peer_out_slots, 2'b10);
    step();
    eq("R6", "notify one cycle", peer_out_valid, 0);
    eq("R7", "no irq before ack", sc_irq, 0);
    finish_event();
  endtask

  task automatic t_split();
    exp_req[5] = 1; exp_type[5] = 1; exp_slots[5*NS +: NS] = 2'b01;
    step(); exp_req = '0; exp_type = '0;
    eq("R3", "dem_type reset", dem_type, 1);
    eq("R5", "split mask", port_stop, 8'h20);
    step();
    finish_event();
  endtask

  task automatic t_priority();
    exp_req[6] = 1; xu_req[1] = 1; xu_type[1] = 1; xu_port[1*PW +: PW] = 3'd1;
    step(); exp_req = '0; xu_req = '0; xu_type = '0;
    eq("R2", "lowest port wins", dem_port, 1);
    eq("R2", "switch unit kind", dem_type, 1);
    eq("R2", "switch unit slots", dem_slots, 0);
    eq("R4", "mask port1", port_stop, want_mask(1));
    eq("R6", "local notify", peer_out_valid, 1);
    step();
    finish_event();
  endtask

  task automatic t_tie();
    exp_req[3] = 1; exp_type[3] = 0; exp_slots[3*NS +: NS] = 2'b01;
    xu_req[0] = 1; xu_type[0] = 1; xu_port[0 +: PW] = 3'd3;
    peer_in_valid = 1; peer_in_type = 1; peer_in_port = 3'd3; peer_in_slots = 2'b11;
    step(); exp_req = '0; xu_req = '0; xu_type = '0; peer_in_valid = 0;
    eq("R2", "tie port", dem_port, 3);
    eq("R2", "tie expander kind", dem_type, 0);
    eq("R2", "tie expander slots", dem_slots, 2'b01);
    step();
    finish_event();
  endtask

  task automatic t_peer();
    peer_in_valid = 1; peer_in_type = 1; peer_in_port = 3'd6; peer_in_slots = 2'b11;
    step(); peer_in_valid = 0;
    eq("R3", "peer port", dem_port, 6);
    eq("R3", "peer slots", dem_slots, 2'b11);
    eq("R4", "mask port6", port_stop, want_mask(6));
    eq("R6", "no notify back to peer", peer_out_valid, 0);
    step();
    finish_event();
  endtask

  task automatic t_backpressure();
    dem_ready = 0;
    exp_req[7] = 1; exp_type[7] = 1; exp_slots[7*NS +: NS] = 2'b11;
    step(); exp_req = '0; exp_type = '0;
    exp_req[0] = 1; ack = '1;
    step(); step(); step();
    exp_req = '0; ack = '0;
    eq("R3", "valid held", dem_valid, 1);
    eq("R8", "busy ignores new request", dem_port, 7);
    eq("R3", "slots held", dem_slots, 2'b11);
    dem_ready = 1;
    step();
    eq("R3", "valid drops after accept", dem_valid, 0);
    step();
    eq("R7", "early acks ignored", sc_irq, 0);
    ack = 4'b0001; step();
    ack = 4'b0100; step();
    ack = 4'b0010; step();
    ack = '0; step();
    eq("R7", "irq waits for last ack", sc_irq, 0);
    ack = 4'b1000; step(); ack = '0;
    eq("R7", "irq after last ack", sc_irq, 1);
    clear_all();
    step();
    eq("R8", "no pending after clear", dem_valid, 0);
    eq("R8", "idle mask", port_stop, 0);
  endtask

  initial begin
    split_cfg = 8'b0010_0000;
    for (int p = 0; p < NE; p++)
      for (int q = 0; q < NE; q++)
        comm_cfg[p*NE+q] = ((p < 4 || p == 5) == (q < 4 || q == 5));
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_nonsplit();
    t_split();
    t_priority();
    t_tie();
    t_peer();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule